// File: doc/BRIEF.md
# FSK Manchester Tag Demodulator

This block turns a stream of 8-bit samples taken from a peak-detected low-frequency antenna into 44-bit tag identifiers. Each accepted sample is reduced to one bit, and the block times the distance between rising edges of that bit. Each distance is sorted into a fast tone or a slow tone, with some tolerance for noisy edges. Runs of equal tone classes are rounded into between one and four half-bit symbols. A deliberately illegal Manchester pattern marks the start of a frame. The half-bits that follow are decoded in pairs into a 64-bit accumulator.

When the next start pattern arrives, a nonzero accumulator is presented for one cycle as a high and low word pair, together with a 16-bit short-form field. The accumulator is then cleared. The block sits behind the sample capture path and ahead of whatever logic consumes the identifiers. It never stalls: it accepts one sample per clock whenever `smp_valid` is high.

Top module: `fsk_tag_demod`

## Requirements
- R1: A sample value of 127 or more is taken as logic 1. A value of 126 or less is taken as logic 0.
- R2: Only 0-to-1 transitions between consecutive accepted samples are timed. The interval is the number of accepted samples from one rising edge to the next. An interval of at most 8 gives a fast class (1), and a longer one gives a slow class (0). Cycles with `smp_valid` low do not count. The first accepted sample can never form a rising edge. The first rising edge only sets the timing reference. The interval count saturates at 255.
- R3: A run of n equal classes ends when a different class arrives. It is rounded with integer division to (n+1)/6 symbols for a fast run and (n+1)/5 symbols for a slow run. Every symbol carries the run's class as its half-bit value. The last run still open is not flushed.
- R4: A rounded count of 0 or 1 gives one half-bit. Counts of 2, 3 and 4 give that many half-bits. Any count above 4 gives no half-bits.
- R5: Six consecutive half-bits that arrive as 1,1,1,0,0,0 form a frame start, and this is checked at every half-bit position. After a frame start, later half-bits are taken in pairs. Half-bits inside the start pattern are never decoded as data.
- R6: The pair (first 1, second 0) decodes to data 0, and the pair (first 0, second 1) decodes to data 1. Each data bit shifts in at bit 0 of the 64-bit accumulator, where `id_hi` is bits 63..32 and `id_lo` is bits 31..0.
- R7: A pair of 0,0 or 1,1 during decoding clears the accumulator and stops decoding until the next frame start. Such a frame produces no output.
- R8: At a frame start, a nonzero accumulator is output with `id_aux` equal to bits 16..1 of the low word, and the accumulator is then cleared. A zero accumulator produces no output.
- R9: `id_valid` is a single-cycle pulse. Between pulses, `id_hi`, `id_lo` and `id_aux` hold their last values. Reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe; `smp_data` is taken when high |
| smp_data | input | 8 | Unsigned ADC sample |
| id_valid | output | 1 | One-cycle pulse: a decoded identifier is present |
| id_hi | output | 32 | Upper word of the identifier accumulator |
| id_lo | output | 32 | Lower word of the identifier accumulator |
| id_aux | output | 16 | Bits 16..1 of `id_lo` at the time of output |

## Verification
A misclassified interval or a wrongly rounded run shifts the pair alignment, so the Manchester decoder sees an illegal pair and drops the frame. At the ports this appears as a missing identifier, or a different one, at the next start pattern, roughly one frame (about 4,700 samples) after the fault. A start pattern detected at the wrong place, or an accumulator that is not cleared, appears as an extra or corrupted pulse at the very next frame start. The stimulus includes jittered tone periods, random amplitudes around the threshold, dead-carrier gaps, over-long tone runs, a corrupted frame and an all-zero frame. These make each of these faults reach the output list.

// File: rtl/fsk_demod_pkg.sv
package fsk_demod_pkg;
   localparam int ID_W      = 64;
   localparam int WORD_W    = ID_W / 2;
   localparam int AUX_W     = 16;
   localparam int MAX_BURST = 4;
   localparam int WIN_W     = 6;
   localparam int FILL_W    = $clog2(WIN_W + 1);
   localparam int BCNT_W    = $clog2(MAX_BURST + 1);
   localparam logic [WIN_W-1:0] SOF_PATTERN = 6'b111000;

   typedef struct packed {
      logic [WIN_W-1:0]  win;
      logic [FILL_W-1:0] fill;
      logic              synced;
      logic              phase;
      logic              first;
      logic [ID_W-1:0]   id;
   } dec_state_t;
endpackage

// File: rtl/fsk_edge_timer.sv
module fsk_edge_timer #(
   parameter int SMP_W    = 8,
   parameter int THRESH   = 127,
   parameter int FAST_MAX = 8,
   parameter int GAP_W    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_valid,
   input  logic [SMP_W-1:0] smp_data,
   output logic             cls_valid,
   output logic             cls_bit
);
   localparam logic [GAP_W-1:0] GAP_MAX = '1;

   logic             level;
   logic             prev_q;
   logic             seen_q;
   logic             rise;
   logic [GAP_W-1:0] gap_q;

   assign level = (int'(smp_data) >= THRESH);
   assign rise  = smp_valid && !prev_q && level;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q    <= 1'b1;
         seen_q    <= 1'b0;
         gap_q     <= '0;
         cls_valid <= 1'b0;
         cls_bit   <= 1'b0;
      end else begin
         cls_valid <= 1'b0;
         if (smp_valid) begin
            prev_q <= level;
            if (rise) begin
               seen_q <= 1'b1;
               gap_q  <= GAP_W'(1);
               if (seen_q) begin
                  cls_valid <= 1'b1;
                  cls_bit   <= (int'(gap_q) <= FAST_MAX);
               end
            end else if (gap_q != GAP_MAX) begin
               gap_q <= gap_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/fsk_run_rounder.sv
module fsk_run_rounder
   import fsk_demod_pkg::*;
#(
   parameter int RUN_W    = 8,
   parameter int FAST_DIV = 6,
   parameter int SLOW_DIV = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cls_valid,
   input  logic              cls_bit,
   output logic              burst_valid,
   output logic              burst_bit,
   output logic [BCNT_W-1:0] burst_cnt
);
   localparam logic [RUN_W-1:0] RUN_MAX = '1;

   logic             have_q;
   logic             run_bit_q;
   logic [RUN_W-1:0] run_len_q;
   logic [RUN_W:0]   len_p1;
   logic [RUN_W:0]   quot;
   logic [BCNT_W-1:0] cnt_c;

   always_comb begin
      len_p1 = {1'b0, run_len_q} + 1'b1;
      quot   = run_bit_q ? len_p1 / (RUN_W+1)'(FAST_DIV)
                         : len_p1 / (RUN_W+1)'(SLOW_DIV);
      if (quot <= 1)
         cnt_c = BCNT_W'(1);
      else if (int'(quot) <= MAX_BURST)
         cnt_c = BCNT_W'(quot);
      else
         cnt_c = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         have_q      <= 1'b0;
         run_bit_q   <= 1'b0;
         run_len_q   <= '0;
         burst_valid <= 1'b0;
         burst_bit   <= 1'b0;
         burst_cnt   <= '0;
      end else begin
         burst_valid <= 1'b0;
         if (cls_valid) begin
            if (!have_q) begin
               have_q    <= 1'b1;
               run_bit_q <= cls_bit;
               run_len_q <= RUN_W'(1);
            end else if (cls_bit == run_bit_q) begin
               if (run_len_q != RUN_MAX) run_len_q <= run_len_q + 1'b1;
            end else begin
               burst_valid <= (cnt_c != '0);
               burst_bit   <= run_bit_q;
               burst_cnt   <= cnt_c;
               run_bit_q   <= cls_bit;
               run_len_q   <= RUN_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/fsk_manch_decoder.sv
module fsk_manch_decoder
   import fsk_demod_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              burst_valid,
   input  logic              burst_bit,
   input  logic [BCNT_W-1:0] burst_cnt,
   output logic              id_valid,
   output logic [WORD_W-1:0] id_hi,
   output logic [WORD_W-1:0] id_lo,
   output logic [AUX_W-1:0]  id_aux
);
   dec_state_t      st_q;
   dec_state_t      st_d;
   logic            emit_c;
   logic [ID_W-1:0] eid_c;

   always_comb begin
      dec_state_t s;
      logic       leave_ok;
      logic       leave_bit;
      s         = st_q;
      emit_c    = 1'b0;
      eid_c     = '0;
      leave_ok  = 1'b0;
      leave_bit = 1'b0;
      for (int k = 0; k < MAX_BURST; k++) begin
         if (burst_valid && (k < int'(burst_cnt))) begin
            leave_ok  = (s.fill == FILL_W'(WIN_W));
            leave_bit = s.win[WIN_W-1];
            s.win     = {s.win[WIN_W-2:0], burst_bit};
            if (!leave_ok) s.fill = s.fill + 1'b1;
            if (leave_ok && s.synced) begin
               if (!s.phase) begin
                  s.first = leave_bit;
                  s.phase = 1'b1;
               end else begin
                  s.phase = 1'b0;
                  if (s.first != leave_bit) begin
                     s.id = {s.id[ID_W-2:0], leave_bit};
                  end else begin
                     s.synced = 1'b0;
                     s.id     = '0;
                  end
               end
            end
            if (s.win == SOF_PATTERN) begin
               if (s.id != '0) begin
                  emit_c = 1'b1;
                  eid_c  = s.id;
               end
               s.id     = '0;
               s.synced = 1'b1;
               s.phase  = 1'b0;
               s.fill   = '0;
            end
         end
      end
      st_d = s;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= '0;
         id_valid <= 1'b0;
         id_hi    <= '0;
         id_lo    <= '0;
         id_aux   <= '0;
      end else begin
         st_q     <= st_d;
         id_valid <= emit_c;
         if (emit_c) begin
            id_hi  <= eid_c[ID_W-1:WORD_W];
            id_lo  <= eid_c[WORD_W-1:0];
            id_aux <= eid_c[AUX_W:1];
         end
      end
   end
endmodule

// File: rtl/fsk_tag_demod.sv
module fsk_tag_demod
   import fsk_demod_pkg::*;
#(
   parameter int SMP_W    = 8,
   parameter int THRESH   = 127,
   parameter int FAST_MAX = 8,
   parameter int GAP_W    = 8,
   parameter int RUN_W    = 8,
   parameter int FAST_DIV = 6,
   parameter int SLOW_DIV = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [SMP_W-1:0]  smp_data,
   output logic              id_valid,
   output logic [WORD_W-1:0] id_hi,
   output logic [WORD_W-1:0] id_lo,
   output logic [AUX_W-1:0]  id_aux
);
   localparam int SMP_MAX = (1 << SMP_W) - 1;

   generate
      if (THRESH < 1 || THRESH > SMP_MAX) begin : g_bad_thresh
         $error("THRESH outside sample range");
      end
      if (FAST_MAX >= (1 << GAP_W) - 1) begin : g_bad_gap
         $error("GAP_W too narrow for FAST_MAX");
      end
      if (FAST_DIV < 1 || SLOW_DIV < 1) begin : g_bad_div
         $error("run divisors must be positive");
      end
   endgenerate

   logic              cls_valid;
   logic              cls_bit;
   logic              burst_valid;
   logic              burst_bit;
   logic [BCNT_W-1:0] burst_cnt;

   fsk_edge_timer #(
      .SMP_W(SMP_W), .THRESH(THRESH), .FAST_MAX(FAST_MAX), .GAP_W(GAP_W)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .cls_valid(cls_valid), .cls_bit(cls_bit)
   );

   fsk_run_rounder #(
      .RUN_W(RUN_W), .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)
   ) u_round (
      .clk(clk), .rst_n(rst_n), .cls_valid(cls_valid), .cls_bit(cls_bit),
      .burst_valid(burst_valid), .burst_bit(burst_bit), .burst_cnt(burst_cnt)
   );

   fsk_manch_decoder u_dec (
      .clk(clk), .rst_n(rst_n), .burst_valid(burst_valid),
      .burst_bit(burst_bit), .burst_cnt(burst_cnt),
      .id_valid(id_valid), .id_hi(id_hi), .id_lo(id_lo), .id_aux(id_aux)
   );
endmodule

// File: rtl/fsk_tag_demod_chk.sv
module fsk_tag_demod_chk
   import fsk_demod_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              smp_valid,
   input logic              cls_valid,
   input logic              burst_valid,
   input logic [BCNT_W-1:0] burst_cnt,
   input logic              id_valid,
   input logic [WORD_W-1:0] id_hi,
   input logic [WORD_W-1:0] id_lo
);
   AST_CLASS_FROM_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      cls_valid |-> $past(smp_valid)); // R2
   AST_CLASS_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      cls_valid |=> !cls_valid); // R2
   AST_BURST_FROM_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      burst_valid |-> $past(cls_valid)); // R3
   AST_BURST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      burst_valid |-> (burst_cnt >= 1 && int'(burst_cnt) <= MAX_BURST)); // R4
   AST_EMIT_FROM_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      id_valid |-> $past(burst_valid)); // R5
   AST_EMIT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      id_valid |-> ((id_hi | id_lo) != '0)); // R8
   AST_EMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      id_valid |=> !id_valid); // R9
   AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !id_valid |-> $stable(id_lo)); // R9
endmodule

bind fsk_tag_demod fsk_tag_demod_chk u_chk (
   .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .cls_valid(cls_valid),
   .burst_valid(burst_valid), .burst_cnt(burst_cnt), .id_valid(id_valid),
   .id_hi(id_hi), .id_lo(id_lo)
);

// File: tb/test_fsk_tag_demod.sv
module test_fsk_tag_demod;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0;
   logic [7:0]  smp_data = 8'd0;
   logic        id_valid;
   logic [31:0] id_hi;
   logic [31:0] id_lo;
   logic [15:0] id_aux;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   bit jit = 1'b0;

   logic [31:0] exp_hi [0:15];
   logic [31:0] exp_lo [0:15];
   logic [31:0] got_hi [0:15];
   logic [31:0] got_lo [0:15];
   logic [15:0] got_aux [0:15];
   int n_exp = 0;
   int n_got = 0;

   always #5 clk = ~clk;

   fsk_tag_demod i_fsk_tag_demod (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .id_valid(id_valid), .id_hi(id_hi), .id_lo(id_lo), .id_aux(id_aux)
   );

   always @(negedge clk) begin
      if (rst_n && id_valid) begin
         if (n_got < 16) begin
            got_hi[n_got]  = id_hi;
            got_lo[n_got]  = id_lo;
            got_aux[n_got] = id_aux;
         end
         n_got = n_got + 1;
      end
   end

   function automatic logic [15:0] aux_of(input logic [31:0] lo);
      return lo[16:1];
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // R1: random amplitudes on each side of the 127 threshold, edges included
   task automatic put_level(input bit b);
      logic [7:0] v;
      if ($urandom % 16 == 0) v = b ? 8'd127 : 8'd126;
      else v = b ? 8'(127 + $urandom % 129) : 8'($urandom % 127);
      @(negedge clk);
      if ($urandom % 8 == 0) begin
         smp_valid = 1'b0;
         smp_data  = 8'($urandom);
         @(negedge clk);
      end
      smp_valid = 1'b1;
      smp_data  = v;
   endtask

   // R2: fast cycles of 7 or 8 samples, slow cycles of 9 to 11 when jittered
   task automatic cyc(input bit fast);
      int len;
      int highs;
      highs = fast ? 2 : 3;
      if (jit) len = fast ? 7 + int'($urandom % 2) : 9 + int'($urandom % 3);
      else len = fast ? 8 : 10;
      for (int i = 0; i < len; i++) put_level(i < highs);
   endtask

   task automatic tone(input bit fast, input int n);
      for (int i = 0; i < n; i++) cyc(fast);
   endtask

   task automatic fc8();  tone(1'b1, 6); endtask
   task automatic fc10(); tone(1'b0, 5); endtask

   task automatic sof_prefix();
      tone(1'b1, 1);
      fc8(); fc8(); fc8(); fc10(); fc10(); fc10(); fc8(); fc10();
   endtask

   task automatic frame(input logic [11:0] hi, input logic [31:0] lo, input int bad);
      bit b;
      sof_prefix();
      for (int j = 43; j >= 0; j--) begin
         b = (j >= 32) ? hi[j-32] : lo[j];
         if (j == bad) begin fc8(); fc8(); end
         else if (b) begin fc10(); fc8(); end
         else begin fc8(); fc10(); end
      end
   endtask

   task automatic push_exp(input logic [11:0] hi, input logic [31:0] lo);
      exp_hi[n_exp] = {20'd0, hi};
      exp_lo[n_exp] = lo;
      n_exp++;
   endtask

   initial begin
      logic [11:0] h;
      logic [31:0] l;
      int seed_dummy;
      seed_dummy = int'($urandom(32'd2718));
      repeat (4) @(negedge clk);
      // R9: reset state
      chk(id_valid == 1'b0, "R9 reset id_valid", 64'(id_valid), 64'd0);
      chk(id_hi == 32'd0 && id_lo == 32'd0, "R9 reset id words", {id_hi, id_lo}, 64'd0);
      chk(id_aux == 16'd0, "R9 reset id_aux", 64'(id_aux), 64'd0);
      rst_n = 1'b1;

      // R4: over-long runs (count above 4) yield nothing; R2 dead carrier gap
      tone(1'b1, 40);
      for (int i = 0; i < 300; i++) put_level(1'b0);
      tone(1'b0, 40);

      // frame A: first start marker carries an empty accumulator (R8)
      h = 12'($urandom); l = $urandom | 32'h1;
      frame(h, l, -1); push_exp(h, l);
      chk(n_got == 0, "R5 R8 no output before second marker", 64'(n_got), 64'd0);

      jit = 1'b1;
      h = 12'($urandom); l = $urandom | 32'h2;
      frame(h, l, -1); push_exp(h, l);
      // R7: corrupted frame (one pair encoded 1,1) is dropped
      h = 12'($urandom); l = $urandom | 32'h4;
      frame(h, l, 20);
      jit = 1'b0;
      h = 12'($urandom); l = $urandom | 32'h8;
      frame(h, l, -1); push_exp(h, l);
      // R8: all-zero identifier is never output
      frame(12'h000, 32'h0, -1);
      jit = 1'b1;
      h = 12'($urandom); l = $urandom | 32'h10;
      frame(h, l, -1); push_exp(h, l);
      jit = 1'b0;
      frame(12'hFFF, 32'hFFFF_FFFF, -1); push_exp(12'hFFF, 32'hFFFF_FFFF);
      sof_prefix();
      fc8();
      @(negedge clk);
      smp_valid = 1'b0;
      repeat (20) @(negedge clk);

      // R3 R5 R7 R8: output count after corrupted and zero frames
      chk(n_got == n_exp, "R3 R5 R7 R8 identifier count", 64'(n_got), 64'(n_exp));
      for (int i = 0; i < n_exp && i < n_got; i++) begin
         chk(got_hi[i] == exp_hi[i], "R6 id_hi", 64'(got_hi[i]), 64'(exp_hi[i]));
         chk(got_lo[i] == exp_lo[i], "R1 R2 R6 id_lo", 64'(got_lo[i]), 64'(exp_lo[i]));
         chk(got_aux[i] == aux_of(exp_lo[i]), "R8 id_aux", 64'(got_aux[i]),
             64'(aux_of(exp_lo[i])));
      end
      // R9: outputs hold the last identifier
      chk(id_lo == 32'hFFFF_FFFF && id_valid == 1'b0, "R9 hold after pulse",
          {31'd0, id_valid, id_lo}, 64'hFFFF_FFFF);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R5 watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule